// File: doc/BRIEF.md
# Hashed-Index Set-Associative Translation Buffer

This block caches virtual-to-physical page translations. It is organised as a small set-associative array. The set is not picked by the low bits of the virtual page number alone. The index is an XOR of the page number's low bits with its high bits, and the high field can be bit-reversed first. One address-space bit also flips the top index bit. As a result, pages that differ only in their upper bits spread across sets instead of piling into one. Consecutive pages still land in different sets, and the same page number in the two address spaces takes separate sets.

A lookup presents a page number and an address-space bit. One cycle later the block returns a hit flag, the physical frame number and the permission bits. A fill writes a translation into the set its own hash selects. The way is chosen in this order: a way that already holds the same page, then the lowest invalid way, then the set's round-robin victim. A flush input empties the whole array in one cycle.

Top module: `vpn_fold_tlb`

## Requirements
- R1: The set index is `vpn[IDX_W-1:0] ^ H ^ (space << (IDX_W-1))`. H is the top IDX_W bits `vpn[VPN_W-1 -: IDX_W]`. When REVERSE_HI=1, H is bit-reversed (bit b takes bit IDX_W-1-b). The defaults are IDX_W=4, VPN_W=20 and reversal on.
- R2: A lookup hits only when a valid entry in its set matches both the full page number and the space bit. On a hit, rsp_pfn and rsp_perm carry the stored values. On a miss, both are zero.
- R3: rsp_valid is lk_valid delayed by exactly one clock. The response belongs to the request sampled at the previous edge.
- R4: A fill goes to the way that already matches its page number and space, if there is one. If not, it goes to the lowest-numbered invalid way. If not, it goes to the way named by the set's round-robin pointer, and that pointer then advances by one modulo WAYS. Pointers are zero after reset and move only on such replacements.
- R5: Flush invalidates every entry at the edge where it is sampled. A lookup sampled with flush reports a miss. A fill sampled with flush is discarded.
- R6: When a fill and a lookup are sampled at the same edge, the lookup sees the array as it was before that fill. The filled entry is visible to lookups sampled from the next edge onward.
- R7: Synchronous active-high reset empties the array and clears rsp_valid, rsp_hit, rsp_pfn and rsp_perm.
- R8: Pages that share their low bits but differ in their top bits map to different sets. With the defaults, such pages can be held at once in greater number than WAYS.
- R9: The same page number in space 0 and space 1 forms two independent entries. Each entry hits only for its own space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_space | input | 1 | Lookup address-space/privilege bit |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | VPN_W | Fill virtual page number |
| fl_space | input | 1 | Fill address-space bit |
| fl_pfn | input | PFN_W | Fill physical frame number |
| fl_perm | input | PERM_W | Fill permission bits |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response valid, one cycle after lk_valid |
| rsp_hit | output | 1 | Translation found |
| rsp_pfn | output | PFN_W | Physical frame number on a hit, else zero |
| rsp_perm | output | PERM_W | Permission bits on a hit, else zero |

## Verification
Any fault in the index hash, the round-robin pointers or the valid bits stays hidden until a later lookup. A wrong index or a lost valid bit shows up as a miss. A wrong victim shows up as a page that misses while it should hit, or a page that hits while it should have been evicted. The effect reaches rsp_hit one cycle after the first lookup of the affected page. Directed sequences therefore force three-way conflicts, same-cycle fill and lookup, and flush overlap. A long random run over a small page pool then makes every set replace repeatedly, and a reference model predicts each response.

// File: rtl/vft_pkg.sv
package vft_pkg;

    localparam int DEF_VPN_W  = 20;
    localparam int DEF_PFN_W  = 18;
    localparam int DEF_PERM_W = 3;
    localparam int DEF_SETS   = 16;
    localparam int DEF_WAYS   = 2;

    // How a fill chose its way
    typedef enum logic [1:0] {
        PICK_MATCH  = 2'd0,
        PICK_FREE   = 2'd1,
        PICK_ROTATE = 2'd2
    } pick_e;

    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vft_index_hash.sv
module vft_index_hash #(
    parameter int VPN_W      = vft_pkg::DEF_VPN_W,
    parameter int IDX_W      = 4,
    parameter bit REVERSE_HI = 1'b1
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic             space,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] lo_part;
    logic [IDX_W-1:0] hi_part;
    logic [IDX_W-1:0] hi_mix;
    logic [IDX_W-1:0] space_mask;

    assign lo_part    = vpn[IDX_W-1:0];
    assign hi_part    = vpn[VPN_W-1 -: IDX_W];
    assign space_mask = IDX_W'(space) << (IDX_W - 1);

    generate
        if (REVERSE_HI) begin : g_rev
            for (genvar b = 0; b < IDX_W; b++) begin : g_bit
                assign hi_mix[b] = hi_part[IDX_W-1-b];
            end
        end else begin : g_fwd
            assign hi_mix = hi_part;
        end
    endgenerate

    assign idx = lo_part ^ hi_mix ^ space_mask;
endmodule

// File: rtl/vft_way_pick.sv
module vft_way_pick
    import vft_pkg::*;
#(
    parameter int WAYS  = vft_pkg::DEF_WAYS,
    parameter int PTR_W = 1
) (
    input  logic [WAYS-1:0]  match_vec,
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [PTR_W-1:0] rr_ptr,
    output logic [PTR_W-1:0] way,
    output pick_e            how,
    output logic [PTR_W-1:0] rr_next
);
    always_comb begin
        way = rr_ptr;
        how = PICK_ROTATE;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                way = PTR_W'(w);
                how = PICK_FREE;
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                way = PTR_W'(w);
                how = PICK_MATCH;
            end
        end
        rr_next = (rr_ptr == PTR_W'(WAYS - 1)) ? '0 : rr_ptr + 1'b1;
    end
endmodule

// File: rtl/vpn_fold_tlb.sv
module vpn_fold_tlb
    import vft_pkg::*;
#(
    parameter int VPN_W      = vft_pkg::DEF_VPN_W,
    parameter int PFN_W      = vft_pkg::DEF_PFN_W,
    parameter int PERM_W     = vft_pkg::DEF_PERM_W,
    parameter int SETS       = vft_pkg::DEF_SETS,
    parameter int WAYS       = vft_pkg::DEF_WAYS,
    parameter bit REVERSE_HI = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_space,
    input  logic              fl_valid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic              fl_space,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic [PERM_W-1:0] fl_perm,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [PERM_W-1:0] rsp_perm
);
    localparam int IDX_W = $clog2(SETS);
    localparam int PTR_W = ptr_width(WAYS);

    typedef struct packed {
        logic [VPN_W-1:0]  tag;
        logic              space;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } entry_t;

    entry_t           mem    [SETS][WAYS];
    logic [WAYS-1:0]  vld    [SETS];
    logic [PTR_W-1:0] rr_ptr [SETS];

    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic [WAYS-1:0]  lk_match, fl_match;
    entry_t           lk_sel, fl_new;
    logic [PTR_W-1:0] fl_way, rr_next;
    pick_e            fl_how;

    vft_index_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W), .REVERSE_HI(REVERSE_HI)) i_lk_hash (
        .vpn(lk_vpn), .space(lk_space), .idx(lk_idx));

    vft_index_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W), .REVERSE_HI(REVERSE_HI)) i_fl_hash (
        .vpn(fl_vpn), .space(fl_space), .idx(fl_idx));

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign lk_match[w] = vld[lk_idx][w] && mem[lk_idx][w].tag == lk_vpn
                                 && mem[lk_idx][w].space == lk_space;
            assign fl_match[w] = vld[fl_idx][w] && mem[fl_idx][w].tag == fl_vpn
                                 && mem[fl_idx][w].space == fl_space;
        end
    endgenerate

    always_comb begin
        lk_sel = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) lk_sel = mem[lk_idx][w];
        end
    end

    vft_way_pick #(.WAYS(WAYS), .PTR_W(PTR_W)) i_pick (
        .match_vec(fl_match), .valid_vec(vld[fl_idx]), .rr_ptr(rr_ptr[fl_idx]),
        .way(fl_way), .how(fl_how), .rr_next(rr_next));

    assign fl_new = '{tag: fl_vpn, space: fl_space, pfn: fl_pfn, perm: fl_perm};

    // Valid bits and replacement pointers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s]    <= '0;
                rr_ptr[s] <= '0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else if (fl_valid) begin
            vld[fl_idx][fl_way] <= 1'b1;
            if (fl_how == PICK_ROTATE) rr_ptr[fl_idx] <= rr_next;
        end
    end

    // Entry payload needs no reset: it is guarded by the valid bits
    always_ff @(posedge clk) begin
        if (!rst && !flush && fl_valid) mem[fl_idx][fl_way] <= fl_new;
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pfn   <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && !flush && (|lk_match);
            rsp_pfn   <= (lk_valid && !flush) ? lk_sel.pfn  : '0;
            rsp_perm  <= (lk_valid && !flush) ? lk_sel.perm : '0;
        end
    end
endmodule

// File: rtl/vpn_fold_tlb_chk.sv
module vpn_fold_tlb_chk #(
    parameter int PFN_W  = 18,
    parameter int PERM_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              flush,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PFN_W-1:0]  rsp_pfn,
    input logic [PERM_W-1:0] rsp_perm
);
    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R2
    hit_has_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0 && rsp_perm == '0));

    // R5
    flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rsp_hit);

    // R5
    post_flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
        flush ##1 lk_valid |=> !rsp_hit);

    // R7
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rsp_valid && !rsp_hit));
endmodule

bind vpn_fold_tlb vpn_fold_tlb_chk #(.PFN_W(PFN_W), .PERM_W(PERM_W)) i_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm));

// File: tb/test_vpn_fold_tlb.sv
`timescale 1ns/1ps
module test_vpn_fold_tlb;
    localparam int VW = 20, PW = 18, RW = 3, NS = 16, NW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 0, lk_space = 0, fl_valid = 0, fl_space = 0, flush = 0;
    logic [VW-1:0] lk_vpn = '0, fl_vpn = '0;
    logic [PW-1:0] fl_pfn = '0;
    logic [RW-1:0] fl_perm = '0;
    logic          rsp_valid, rsp_hit;
    logic [PW-1:0] rsp_pfn;
    logic [RW-1:0] rsp_perm;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model
    bit            m_vld  [NS][NW];
    logic [VW-1:0] m_tag  [NS][NW];
    bit            m_sp   [NS][NW];
    logic [PW-1:0] m_pfn  [NS][NW];
    logic [RW-1:0] m_perm [NS][NW];
    int            m_rr   [NS];

    always #5 clk = ~clk;

    vpn_fold_tlb i_vpn_fold_tlb (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_space(lk_space),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_space(fl_space), .fl_pfn(fl_pfn),
        .fl_perm(fl_perm), .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm));

    // R1 index formula, defaults: 4 index bits, top field reversed
    function automatic int set_of(logic [VW-1:0] v, bit sp);
        logic [3:0] hi, r;
        hi = v[VW-1 -: 4];
        for (int b = 0; b < 4; b++) r[b] = hi[3-b];
        return int'(v[3:0] ^ r ^ {sp, 3'b000});
    endfunction

    function automatic int find_way(int s, logic [VW-1:0] v, bit sp);
        for (int w = 0; w < NW; w++)
            if (m_vld[s][w] && m_tag[s][w] == v && m_sp[s][w] == sp) return w;
        return -1;
    endfunction

    task automatic check(bit ok, string rq, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic step(bit lk, logic [VW-1:0] lv, bit ls, bit fl, logic [VW-1:0] fv, bit fs,
                        logic [PW-1:0] fp, logic [RW-1:0] fr, bit fsh, string rq);
        int s, w;
        bit e_hit;
        logic [PW-1:0] e_pfn;
        logic [RW-1:0] e_perm;
        @(negedge clk);
        lk_valid = lk; lk_vpn = lv; lk_space = ls;
        fl_valid = fl; fl_vpn = fv; fl_space = fs; fl_pfn = fp; fl_perm = fr; flush = fsh;
        s = set_of(lv, ls);
        w = find_way(s, lv, ls);
        e_hit  = lk && !fsh && w >= 0;
        e_pfn  = e_hit ? m_pfn[s][w]  : '0;
        e_perm = e_hit ? m_perm[s][w] : '0;
        @(posedge clk);
        #1;
        check(rsp_valid == lk, "R3", "rsp_valid", rsp_valid, lk);
        if (lk) begin
            check(rsp_hit == e_hit, rq, "hit", rsp_hit, e_hit);
            check(rsp_pfn == e_pfn, rq, "pfn", rsp_pfn, e_pfn);
            check(rsp_perm == e_perm, rq, "perm", rsp_perm, e_perm);
        end
        // model update
        if (fsh) begin
            for (int a = 0; a < NS; a++) for (int b = 0; b < NW; b++) m_vld[a][b] = 0;
        end else if (fl) begin
            s = set_of(fv, fs);
            w = find_way(s, fv, fs);
            if (w < 0) for (int b = NW - 1; b >= 0; b--) if (!m_vld[s][b]) w = b;
            if (w < 0) begin
                w = m_rr[s];
                m_rr[s] = (m_rr[s] + 1) % NW;
            end
            m_vld[s][w] = 1; m_tag[s][w] = fv; m_sp[s][w] = fs;
            m_pfn[s][w] = fp; m_perm[s][w] = fr;
        end
    endtask

    task automatic look(logic [VW-1:0] v, bit sp, string rq);
        step(1, v, sp, 0, '0, 0, '0, '0, 0, rq);
    endtask

    task automatic fill(logic [VW-1:0] v, bit sp, logic [PW-1:0] p, logic [RW-1:0] r, string rq);
        step(0, '0, 0, 1, v, sp, p, r, 0, rq);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NS; a++) begin
            m_rr[a] = 0;
            for (int b = 0; b < NW; b++) m_vld[a][b] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R7 reset state
        check(rsp_valid == 0 && rsp_hit == 0, "R7", "reset outputs", {rsp_valid, rsp_hit}, 0);
        look(20'h00000, 0, "R7");

        // R2 basic hit and exact-tag requirement
        fill(20'h12345, 0, 18'h2abcd, 3'd5, "R2");
        look(20'h12345, 0, "R2");
        look(20'h12355, 0, "R2");

        // R1 + R4: three pages that the formula puts in set 0
        fill(20'h00000, 0, 18'h00011, 3'd1, "R4");
        fill(20'h10008, 0, 18'h00022, 3'd2, "R4");
        fill(20'h20004, 0, 18'h00033, 3'd3, "R4");
        look(20'h00000, 0, "R1");
        look(20'h10008, 0, "R1");
        look(20'h20004, 0, "R4");
        fill(20'h30000 ^ 20'h0000c, 0, 18'h00044, 3'd4, "R4");
        look(20'h10008, 0, "R4");
        // refill of a present page overwrites in place
        fill(20'h20004, 0, 18'h00055, 3'd6, "R4");
        look(20'h20004, 0, "R4");
        look(20'h3000c, 0, "R4");

        // R8 same low bits, different top bits: all kept
        fill(20'h00005, 0, 18'h00101, 3'd1, "R8");
        fill(20'h10005, 0, 18'h00102, 3'd2, "R8");
        fill(20'h20005, 0, 18'h00103, 3'd3, "R8");
        look(20'h00005, 0, "R8");
        look(20'h10005, 0, "R8");
        look(20'h20005, 0, "R8");

        // R9 address spaces
        fill(20'h0abc1, 0, 18'h00200, 3'd1, "R9");
        look(20'h0abc1, 1, "R9");
        fill(20'h0abc1, 1, 18'h00300, 3'd2, "R9");
        look(20'h0abc1, 0, "R9");
        look(20'h0abc1, 1, "R9");

        // R6 fill and lookup of the same page together
        step(1, 20'h55555, 0, 1, 20'h55555, 0, 18'h00777, 3'd7, 0, "R6");
        look(20'h55555, 0, "R6");

        // R5 flush with lookup, and with fill
        step(1, 20'h55555, 0, 0, '0, 0, '0, '0, 1, "R5");
        look(20'h55555, 0, "R5");
        step(0, '0, 0, 1, 20'h66666, 0, 18'h00888, 3'd1, 1, "R5");
        look(20'h66666, 0, "R5");

        // random mix over a small page pool
        for (int i = 0; i < 3000; i++) begin
            logic [VW-1:0] lv, fv;
            lv = {2'b00, 2'($urandom % 4), 11'd0, 1'($urandom % 2), 4'($urandom % 16)};
            fv = {2'b00, 2'($urandom % 4), 11'd0, 1'($urandom % 2), 4'($urandom % 16)};
            step(($urandom % 10) < 7, lv, 1'($urandom % 2),
                 ($urandom % 10) < 4, fv, 1'($urandom % 2),
                 18'($urandom), 3'($urandom), ($urandom % 100) == 0, "R2");
        end
        step(0, '0, 0, 0, '0, 0, '0, '0, 0, "R3");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial void'($urandom(32'h5eed_7b1));
endmodule